// File: doc/BRIEF.md
# Skip-List Candidate Block Search with Path Reuse

This block locates the compressed block of a long posting list that may hold a given document identifier. A posting list is split into blocks, and the first identifier of each block is stored uncompressed in a skip array. For each query identifier the block runs a binary search over that skip array only, never over the postings inside a block. It reports the index of the last block whose skip value does not exceed the query, together with that skip value. A separate unit then fetches and decodes the candidate block; that step is outside this block.

Skip values sit in memory, one per word, starting at a base address. They are read through a request/response port whose latency varies. Queries usually arrive in ascending order, so successive searches tend to share the top of their search path. A path store keeps, for each depth of the last search, the skip value visited and the direction taken. A new search walks the stored nodes, at one cycle per node, for as long as it goes the same way as before. The node where it first turns the other way is still taken from the store. Every node after it is read from memory, and the store is rewritten along the new path. Loading a list drops the whole store. The block handles one search at a time.

Top module: `skp_search`

## Requirements
- R1: The result is the largest index i with skip[i] <= docID; `res_found` is 1, `res_index` is i and `res_skip` is skip[i]. An exact match selects that block.
- R2: If docID is below skip[0], `res_found` is 0 and `res_skip` is 0.
- R3: If docID is at or above the last skip value, the result is index len-1.
- R4: The search range starts as [0, len-1]. Each node is mid = floor((lo+hi)/2) and is read at address base + mid. A search with an empty path store first reads base + floor((len-1)/2).
- R5: Nodes on the stored path are reused while the new search has taken the same direction at every earlier depth. The node where the direction first differs is also reused; only the nodes after it are read from memory. Repeating the previous query therefore reads nothing.
- R6: A list load empties the path store, so the next search reads every node it visits from memory.
- R7: `q_ready` is low from the cycle after a query is accepted until the search has finished. `res_valid` is a single-cycle pulse for each accepted query.
- R8: A memory request keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` is seen. Any response latency of one or more cycles is accepted.
- R9: With a list length of 0, a query returns `res_found` = 0 and makes no memory request.
- R10: After reset, `q_ready` and `load_ready` are 1, and `res_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Load a new skip list (takes priority over a query) |
| load_ready | output | 1 | High while idle; a load is taken when both are high |
| load_base | input | ADDR_W | Word address of skip[0] |
| load_len | input | IDX_W | Number of skip values |
| q_valid | input | 1 | Query present |
| q_ready | output | 1 | Query accepted when both are high |
| q_docid | input | DATA_W | Query document identifier |
| mem_req_valid | output | 1 | Skip value read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Word address to read |
| mem_rsp_valid | input | 1 | Read data present, one cycle |
| mem_rsp_data | input | DATA_W | Skip value read |
| res_valid | output | 1 | Result pulse |
| res_found | output | 1 | A candidate block exists |
| res_index | output | IDX_W | Candidate block index |
| res_skip | output | DATA_W | Skip value of the candidate block |

## Verification
A stored node whose value or direction is wrong shows up at the ports in one of two ways. The result of the same search carries a wrong index or skip value. Or the number of memory reads for that search differs from the count predicted by the reuse rule. Both are visible on the result pulse, so the bench counts reads per query and compares the count with the result. A store that survives a list load shows up on the very first search after the load, as too few reads. A search on a freshly loaded list also reveals a wrong midpoint, because its first read address must be the root of the range.

// File: rtl/skp_pkg.sv
package skp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_REQ,
        ST_WAIT,
        ST_RESP
    } skp_state_e;
endpackage

// File: rtl/skp_bisect.sv
// One bisection step: midpoint of the live range, direction and next bounds.
module skp_bisect #(
    parameter int IDX_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic signed [IDX_W:0]  lo,
    input  logic signed [IDX_W:0]  hi,
    input  logic [DATA_W-1:0]      key,
    input  logic [DATA_W-1:0]      probe_val,
    output logic                   range_empty,
    output logic [IDX_W-1:0]       mid,
    output logic                   go_right,
    output logic signed [IDX_W:0]  lo_next,
    output logic signed [IDX_W:0]  hi_next
);
    logic signed [IDX_W+1:0] sum;
    logic signed [IDX_W+1:0] mid_s;

    assign sum         = {lo[IDX_W], lo} + {hi[IDX_W], hi};
    assign mid_s       = sum >>> 1;
    assign range_empty = lo > hi;
    assign mid         = IDX_W'(mid_s);
    assign go_right    = probe_val <= key;
    assign lo_next     = (IDX_W+1)'(mid_s + 1);
    assign hi_next     = (IDX_W+1)'(mid_s - 1);
endmodule

// File: rtl/skp_path_cache.sv
// Per-depth store of the last search path: skip value and direction taken.
module skp_path_cache #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              wr_dir,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_val,
    output logic              rd_dir
);
    logic [DATA_W-1:0] val_q [DEPTH];
    logic [DEPTH-1:0]  dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) val_q[i] <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            val_q[wr_idx] <= wr_val;
            dir_q[wr_idx] <= wr_dir;
        end
    end

    assign rd_val = val_q[rd_idx];
    assign rd_dir = dir_q[rd_idx];
endmodule

// File: rtl/skp_search.sv
module skp_search
    import skp_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 16,
    parameter int CACHE_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    output logic              load_ready,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [IDX_W-1:0]  load_len,
    input  logic              q_valid,
    output logic              q_ready,
    input  logic [DATA_W-1:0] q_docid,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic              res_found,
    output logic [IDX_W-1:0]  res_index,
    output logic [DATA_W-1:0] res_skip
);
    localparam int CI_W  = $clog2(CACHE_DEPTH);
    localparam int DEP_W = $clog2(CACHE_DEPTH + 1);

    typedef struct packed {
        skp_state_e        state;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  len;
        logic [DATA_W-1:0] key;
        logic [IDX_W:0]    lo;
        logic [IDX_W:0]    hi;
        logic [DEP_W-1:0]  depth;
        logic [DEP_W-1:0]  path_len;
        logic              follow;
        logic              ans_ok;
        logic [IDX_W-1:0]  ans_idx;
        logic [DATA_W-1:0] ans_val;
    } srch_t;

    srch_t q, d;

    logic              range_empty, go_right, hit, take;
    logic [IDX_W-1:0]  mid;
    logic [IDX_W:0]    lo_next, hi_next;
    logic [DATA_W-1:0] probe_val, rd_val;
    logic              rd_dir, cw_en;
    logic [ADDR_W-1:0] cur_base;
    logic [IDX_W-1:0]  cur_len;

    assign hit       = q.follow && (q.depth < q.path_len);
    assign probe_val = (q.state == ST_WAIT) ? mem_rsp_data : rd_val;
    assign take      = ((q.state == ST_PROBE) && !range_empty && hit)
                    || ((q.state == ST_WAIT) && mem_rsp_valid);
    assign cw_en     = take;

    skp_bisect #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_step (
        .lo          (q.lo),
        .hi          (q.hi),
        .key         (q.key),
        .probe_val   (probe_val),
        .range_empty (range_empty),
        .mid         (mid),
        .go_right    (go_right),
        .lo_next     (lo_next),
        .hi_next     (hi_next)
    );

    skp_path_cache #(.DEPTH(CACHE_DEPTH), .DATA_W(DATA_W)) u_path (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cw_en),
        .wr_idx (q.depth[CI_W-1:0]),
        .wr_val (probe_val),
        .wr_dir (go_right),
        .rd_idx (q.depth[CI_W-1:0]),
        .rd_val (rd_val),
        .rd_dir (rd_dir)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (load_valid) begin
                    d.base     = load_base;
                    d.len      = load_len;
                    d.path_len = '0;
                end else if (q_valid) begin
                    d.key     = q_docid;
                    d.lo      = '0;
                    d.hi      = {1'b0, q.len} - 1'b1;
                    d.depth   = '0;
                    d.follow  = 1'b1;
                    d.ans_ok  = 1'b0;
                    d.ans_idx = '0;
                    d.ans_val = '0;
                    d.state   = ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (range_empty) begin
                    d.path_len = q.depth;
                    d.state    = ST_RESP;
                end else if (!hit) begin
                    d.state = ST_REQ;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) d.state = ST_PROBE;
            end
            ST_RESP: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase

        if (take) begin
            if (!hit || (rd_dir != go_right)) d.follow = 1'b0;
            d.depth = q.depth + DEP_W'(1);
            if (go_right) begin
                d.ans_ok  = 1'b1;
                d.ans_idx = mid;
                d.ans_val = probe_val;
                d.lo      = lo_next;
            end else begin
                d.hi = hi_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign load_ready    = (q.state == ST_IDLE);
    assign q_ready       = (q.state == ST_IDLE) && !load_valid;
    assign mem_req_valid = (q.state == ST_REQ);
    assign mem_req_addr  = q.base + ADDR_W'(mid);
    assign res_valid     = (q.state == ST_RESP);
    assign res_found     = q.ans_ok;
    assign res_index     = q.ans_idx;
    assign res_skip      = q.ans_val;
    assign cur_base      = q.base;
    assign cur_len       = q.len;
endmodule

// File: rtl/skp_search_chk.sv
module skp_search_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              q_valid,
    input logic              q_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              res_valid,
    input logic              res_found,
    input logic [IDX_W-1:0]  res_index,
    input logic [ADDR_W-1:0] cur_base,
    input logic [IDX_W-1:0]  cur_len
);
    a_r7_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_ready) |=> !q_ready);

    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r4_addr_in_list: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ((mem_req_addr >= cur_base)
                        && ((mem_req_addr - cur_base) < ADDR_W'(cur_len))));

    a_r1_index_in_list: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_found) |-> (res_index < cur_len));

    a_r9_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (cur_len == '0)) |-> !res_found);
endmodule

bind skp_search skp_search_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .q_valid       (q_valid),
    .q_ready       (q_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .res_valid     (res_valid),
    .res_found     (res_found),
    .res_index     (res_index),
    .cur_base      (cur_base),
    .cur_len       (cur_len)
);

// File: tb/tb_skp_search.sv
`timescale 1ns/1ps
module tb_skp_search;
    localparam int ADDR_W = 32, DATA_W = 32, IDX_W = 16, CACHE_DEPTH = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic load_valid = 1'b0, load_ready;
    logic [ADDR_W-1:0] load_base = '0;
    logic [IDX_W-1:0]  load_len = '0;
    logic q_valid = 1'b0, q_ready;
    logic [DATA_W-1:0] q_docid = '0;
    logic mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_rsp_data;
    logic res_valid, res_found;
    logic [IDX_W-1:0] res_index;
    logic [DATA_W-1:0] res_skip;

    always #10 clk = ~clk;

    skp_search #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CACHE_DEPTH(CACHE_DEPTH)) dut (.*);

    typedef struct {
        bit found; int idx; int unsigned skip; int reads; int unsigned first_addr; string tag;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0, errors = 0;
    bit timed_out = 0;
    int unsigned model_mem [256];
    int unsigned lst[$];
    int unsigned base_m = 0;
    int plen = 0;
    bit pdir [32];
    int cur_reads = 0;
    int unsigned cur_first = 0;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Reference of the search and reuse rules (R1-style result, R5 read count)
    task automatic model(input int unsigned key, input string tag, output exp_t e);
        int lo = 0, hi = lst.size() - 1, k = 0;
        bit fol = 1;
        e.found = 0; e.idx = 0; e.skip = 0; e.reads = 0; e.first_addr = 0; e.tag = tag;
        while (lo <= hi) begin
            int mid = (lo + hi) / 2;
            bit hitc = fol && (k < plen);
            bit r;
            if (!hitc) begin
                if (e.reads == 0) e.first_addr = base_m + mid;
                e.reads++;
            end
            r = lst[mid] <= key;
            if (!hitc || pdir[k] != r) fol = 0;
            pdir[k] = r;
            k++;
            if (r) begin e.found = 1; e.idx = mid; e.skip = lst[mid]; lo = mid + 1; end
            else hi = mid - 1;
        end
        plen = k;
    endtask

    task automatic load_list(input int unsigned base, input int unsigned vals[$]);
        @(negedge clk);
        while (!load_ready) @(negedge clk);
        lst = vals; base_m = base; plen = 0;
        foreach (vals[i]) model_mem[(base + i) % 256] = vals[i];
        load_valid = 1; load_base = base; load_len = IDX_W'(vals.size());
        @(negedge clk);
        load_valid = 0;
    endtask

    task automatic search(input int unsigned key, input string tag);
        exp_t e;
        @(negedge clk);
        while (!q_ready) @(negedge clk);
        model(key, tag, e);
        exp_q.push_back(e);
        q_valid = 1; q_docid = key;
        @(negedge clk);
        q_valid = 0;
        chk(!q_ready, "R7", "q_ready low while busy", q_ready, 0);
        while (exp_q.size() != 0 && !timed_out) @(negedge clk);
    endtask

    // Memory model: random ready, variable latency, R4/R8 checks
    initial begin
        int lat = 0;
        bit stall_prev = 0;
        logic [ADDR_W-1:0] stall_addr = '0, rsp_addr = '0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (stall_prev)
                chk(mem_req_valid && mem_req_addr == stall_addr, "R8", "request held",
                    mem_req_addr, stall_addr);
            stall_prev = 0;
            if (lat > 0) begin
                mem_req_ready = 0;
                lat--;
                if (lat == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data = model_mem[rsp_addr % 256];
                end
            end else begin
                mem_req_ready = ($urandom_range(0, 2) != 0);
                if (mem_req_valid && mem_req_ready) begin
                    chk(mem_req_addr >= base_m && mem_req_addr < base_m + lst.size(), "R4",
                        "read address in list", mem_req_addr, base_m);
                    if (cur_reads == 0) cur_first = mem_req_addr;
                    cur_reads++;
                    rsp_addr = mem_req_addr;
                    lat = $urandom_range(1, 4);
                end else if (mem_req_valid) begin
                    stall_prev = 1; stall_addr = mem_req_addr;
                end
            end
        end
    end

    // Monitor: pop expected items as results appear
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "unexpected result", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(res_found == e.found, e.tag, "found", res_found, e.found);
                    if (e.found) chk(res_index == e.idx, e.tag, "index", res_index, e.idx);
                    chk(res_skip == e.skip, e.tag, "skip", res_skip, e.skip);
                    chk(cur_reads == e.reads, "R5", "memory reads", cur_reads, e.reads);
                    if (e.reads > 0 && cur_reads > 0)
                        chk(cur_first == e.first_addr, "R4", "first read address", cur_first, e.first_addr);
                end
                cur_reads = 0;
                @(negedge clk);
                chk(!res_valid, "R7", "result single pulse", res_valid, 0);
            end
        end
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        timed_out = 1;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned v[$];
        int unsigned key;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(q_ready == 1, "R10", "q_ready after reset", q_ready, 1);
        chk(load_ready == 1, "R10", "load_ready after reset", load_ready, 1);
        chk(res_valid == 0, "R10", "res_valid after reset", res_valid, 0);
        chk(mem_req_valid == 0, "R10", "mem_req_valid after reset", mem_req_valid, 0);

        load_list(100, '{1, 8, 19, 37, 48, 54, 76});
        search(40, "R1");      // cold: 3 reads, index 3
        search(64, "R5");      // diverges at 54: 1 read, index 5
        search(64, "R5");      // full reuse: 0 reads
        search(0, "R2");       // below first skip value
        search(100, "R3");     // beyond last skip value
        search(76, "R3");      // equal to last skip value
        search(37, "R1");      // exact match

        load_list(100, '{1, 8, 19, 37, 48, 54, 76});
        search(40, "R6");      // store emptied: 3 reads again

        load_list(150, '{500});
        search(499, "R2");
        search(500, "R1");
        search(9999, "R3");

        v.delete();
        load_list(60, v);
        search(5, "R9");

        v.delete();
        key = 3;
        for (int i = 0; i < 40; i++) begin
            v.push_back(key);
            key += $urandom_range(1, 20);
        end
        load_list(20, v);
        key = 0;
        for (int i = 0; i < 60; i++) begin
            search(key, "R1");
            key += $urandom_range(0, 25);
        end

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule